// File: doc/BRIEF.md
# NOR flash command sequencer

This block models the command interface of a byte-wide NOR flash device on top of a small on-chip byte array. The host drives an address, a data byte and three active-low strobes. A write is any clock cycle in which chip enable and write enable are both low. A read is any cycle in which chip enable and output enable are both low. Multi-cycle unlock sequences start an embedded byte program, a whole-array erase or a single-sector erase. Each operation then runs as a timed internal sequence with no further help from the host.

While an operation runs, the data bus returns a status byte instead of array contents. A program that tries to raise a stored 0 to a 1 leaves the device in a sticky error state. A per-sector protect vector keeps chosen sectors out of every erase. The hardware reset aborts whatever is running. The array itself is never cleared by reset. With the defaults, the array holds 128 bytes in four sectors of 32 bytes, and the sector index is address bits [6:5].

Top module: `nor_flash_cmd`

## Requirements
- R1: In read mode, a read returns the array byte at addr_i[6:0]. On any cycle that is not a read, data_o is 0x00.
- R2: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), (A,D) program byte A. Eight cycles after the last write, the byte becomes old AND D and the device is back in read mode. Bytes may be programmed at any address in any order.
- R3: In an unlock or setup cycle, a write whose address or data does not match sends the decoder back to read mode. A 0xF0 write mid-sequence does the same, and no operation starts.
- R4: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) erase every unprotected sector in ascending order, taking 64 cycles per sector, and then the device returns to read mode.
- R5: The same five leading writes followed by a write of data 0x30 to any address erase only the sector selected by that address's bits [6:5].
- R6: Sectors whose protect_i bit is 1 when the erase is issued are skipped. If no sector is left to erase, the device stays in read mode without any busy cycle.
- R7: In cycle k of a sector's erase (k = 0..63), byte k of the sector is cleared to 0x00 when k < 32, and byte k-32 is set to 0xFF when k >= 32.
- R8: While an operation is running or the error state holds, a read returns a status byte. Bit 7 is the complement of bit 7 of the target data (program data, or 0xFF for an erase). Bit 6 inverts on each successive status read. Bit 5 is 1 only in the error state. Bits 4..0 are 0.
- R9: All bus writes are ignored while a program or erase is running.
- R10: A program that asks for a 1 over a stored 0 ends in an error state. The stored byte is still old AND D. The state holds, and all other writes are ignored, until a write of data 0xF0 at any address returns the device to read mode.
- R11: Asserting rst_ni low aborts any operation immediately and returns to read mode. Bytes already changed by the aborted operation keep their new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| addr_i | input | 11 | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status byte |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| protect_i | input | 4 | Per-sector erase protect, 1 = protected |

## Verification
The assertions check these rules on every cycle:
- The bus stays quiet outside reads.
- The status byte has the correct shape, and bit 6 alternates between consecutive status reads.
- The error flag is shown and stays sticky until a 0xF0 write.
- The command decoder stays idle while an operation runs.

Only the bench scenarios can show the following:
- The result of AND-only programming.
- The exact per-sector erase timing and the byte-by-byte erase pattern.
- Skipping of protected sectors.
- Recovery from broken unlock sequences.
- What a reset abort leaves in the array.

These are shown by comparing every cycle against a behavioural model.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [2:0] {
    DEC_READ, DEC_UNLK1, DEC_UNLK2, DEC_PROG, DEC_ERS3, DEC_ERS4, DEC_ERS5
  } dec_state_e;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE, OP_ERR} op_state_e;

  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [10:0] ADR_UNLK_A = 11'h555;
  localparam logic [10:0] ADR_UNLK_B = 11'h2AA;
endpackage

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
  parameter int MEM_AW = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 2 ** MEM_AW;

  // non-volatile: contents survive reset
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nor_flash_decoder.sv
module nor_flash_decoder
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              prog_go_o,
  output logic              chip_go_o,
  output logic              sect_go_o,
  output dec_state_e        state_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(ADR_UNLK_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(ADR_UNLK_B);

  dec_state_e state_q, state_d;
  logic at_a, hit_a, hit_b;

  assign at_a  = (addr_i == ADR_A);
  assign hit_a = at_a && (data_i == CMD_UNLK_A);
  assign hit_b = (addr_i == ADR_B) && (data_i == CMD_UNLK_B);

  always_comb begin
    state_d   = state_q;
    prog_go_o = 1'b0;
    chip_go_o = 1'b0;
    sect_go_o = 1'b0;
    if (wr_i) begin
      case (state_q)
        DEC_READ:  state_d = hit_a ? DEC_UNLK1 : DEC_READ;
        DEC_UNLK1: state_d = hit_b ? DEC_UNLK2 : DEC_READ;
        DEC_UNLK2: begin
          if (at_a && data_i == CMD_PROG)       state_d = DEC_PROG;
          else if (at_a && data_i == CMD_ERASE) state_d = DEC_ERS3;
          else                                  state_d = DEC_READ;
        end
        DEC_PROG: begin
          prog_go_o = 1'b1;
          state_d   = DEC_READ;
        end
        DEC_ERS3: state_d = hit_a ? DEC_ERS4 : DEC_READ;
        DEC_ERS4: state_d = hit_b ? DEC_ERS5 : DEC_READ;
        DEC_ERS5: begin
          chip_go_o = at_a && (data_i == CMD_CHIP);
          sect_go_o = (data_i == CMD_SECT);
          state_d   = DEC_READ;
        end
        default: state_d = DEC_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DEC_READ;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/nor_flash_engine.sv
module nor_flash_engine
  import nor_flash_pkg::*;
#(
  parameter int MEM_AW   = 7,
  parameter int SECT_W   = 2,
  parameter int PROG_CYC = 8,
  localparam int NSECT   = 2 ** SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_go_i,
  input  logic              chip_go_i,
  input  logic              sect_go_i,
  input  logic [MEM_AW-1:0] go_addr_i,
  input  logic [7:0]        go_data_i,
  input  logic [NSECT-1:0]  protect_i,
  input  logic              clr_err_i,
  input  logic [7:0]        rd_data_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [MEM_AW-1:0] tgt_addr_o,
  output logic              tgt_bit7_o,
  output op_state_e         state_o
);
  localparam int SB_W      = MEM_AW - SECT_W;
  localparam int ERASE_CYC = 2 ** (SB_W + 1);
  localparam int CNT_MAX   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX);

  op_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MEM_AW-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  logic [NSECT-1:0]  mask_q, next_mask, start_mask;
  logic [SECT_W-1:0] cur_sect;
  logic              prog_last, erase_last;

  assign start_mask = chip_go_i ? ~protect_i
                    : ((NSECT'(1) << go_addr_i[MEM_AW-1 -: SECT_W]) & ~protect_i);

  // lowest pending sector first
  always_comb begin
    cur_sect = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (mask_q[i]) cur_sect = SECT_W'(i);
    end
  end
  assign next_mask = mask_q & ~(NSECT'(1) << cur_sect);

  assign prog_last  = (state_q == OP_PROG)  && (cnt_q == CNT_W'(PROG_CYC - 1));
  assign erase_last = (state_q == OP_ERASE) && (cnt_q == CNT_W'(ERASE_CYC - 1));

  always_comb begin
    mem_we_o    = 1'b0;
    mem_waddr_o = tgt_addr_q;
    mem_wdata_o = rd_data_i & tgt_data_q;
    if (prog_last) begin
      mem_we_o = 1'b1;
    end else if (state_q == OP_ERASE) begin
      mem_we_o    = 1'b1;
      mem_waddr_o = {cur_sect, cnt_q[SB_W-1:0]};
      mem_wdata_o = cnt_q[SB_W] ? 8'hFF : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= OP_IDLE;
      cnt_q      <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= 8'hFF;
      mask_q     <= '0;
    end else begin
      case (state_q)
        OP_IDLE: begin
          cnt_q <= '0;
          if (prog_go_i) begin
            tgt_addr_q <= go_addr_i;
            tgt_data_q <= go_data_i;
            state_q    <= OP_PROG;
          end else if ((chip_go_i || sect_go_i) && start_mask != '0) begin
            mask_q     <= start_mask;
            tgt_data_q <= 8'hFF;
            state_q    <= OP_ERASE;
          end
        end
        OP_PROG: begin
          if (prog_last)
            state_q <= ((tgt_data_q & ~rd_data_i) != 8'h00) ? OP_ERR : OP_IDLE;
          else
            cnt_q <= cnt_q + 1'b1;
        end
        OP_ERASE: begin
          cnt_q <= cnt_q + 1'b1;
          if (erase_last) begin
            cnt_q  <= '0;
            mask_q <= next_mask;
            if (next_mask == '0) state_q <= OP_IDLE;
          end
        end
        OP_ERR: if (clr_err_i) state_q <= OP_IDLE;
        default: state_q <= OP_IDLE;
      endcase
    end
  end

  assign tgt_addr_o = tgt_addr_q;
  assign tgt_bit7_o = tgt_data_q[7];
  assign state_o    = state_q;
endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
  import nor_flash_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int MEM_AW   = 7,
  parameter int SECT_W   = 2,
  parameter int PROG_CYC = 8,
  localparam int NSECT   = 2 ** SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [NSECT-1:0]  protect_i
);
  logic wr, rd, op_busy, op_err, dec_idle, tog_q;
  logic prog_go, chip_go, sect_go, mem_we, tgt_bit7;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr, tgt_addr;
  logic [7:0] mem_wdata, mem_rdata;
  dec_state_e dec_state;
  op_state_e  op_state;

  assign wr       = !ce_ni && !we_ni;
  assign rd       = !ce_ni && !oe_ni;
  assign op_busy  = (op_state != OP_IDLE);
  assign op_err   = (op_state == OP_ERR);
  assign dec_idle = (dec_state == DEC_READ);

  nor_flash_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni,
    .wr_i      (wr && !op_busy),
    .addr_i,
    .data_i,
    .prog_go_o (prog_go),
    .chip_go_o (chip_go),
    .sect_go_o (sect_go),
    .state_o   (dec_state)
  );

  nor_flash_engine #(.MEM_AW(MEM_AW), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC)) u_eng (
    .clk_i, .rst_ni,
    .prog_go_i   (prog_go),
    .chip_go_i   (chip_go),
    .sect_go_i   (sect_go),
    .go_addr_i   (addr_i[MEM_AW-1:0]),
    .go_data_i   (data_i),
    .protect_i,
    .clr_err_i   (wr && op_err && data_i == CMD_RESET),
    .rd_data_i   (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_wdata_o (mem_wdata),
    .tgt_addr_o  (tgt_addr),
    .tgt_bit7_o  (tgt_bit7),
    .state_o     (op_state)
  );

  assign mem_raddr = op_busy ? tgt_addr : addr_i[MEM_AW-1:0];

  nor_flash_array #(.MEM_AW(MEM_AW)) u_arr (
    .clk_i,
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tog_q <= 1'b0;
    else if (rd && op_busy) tog_q <= ~tog_q;
  end

  always_comb begin
    if (!rd)         data_o = 8'h00;
    else if (op_busy) data_o = {~tgt_bit7, tog_q, op_err, 5'b00000};
    else             data_o = mem_rdata;
  end
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       we_ni,
  input logic       oe_ni,
  input logic [7:0] data_i,
  input logic [7:0] data_o,
  input logic       busy,
  input logic       err,
  input logic       dec_idle
);
  logic rd, wr;
  assign rd = !ce_ni && !oe_ni;
  assign wr = !ce_ni && !we_ni;

  // R1
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> data_o == 8'h00);

  // R8
  status_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy) |-> (data_o[4:0] == 5'b0 && data_o[5] == err));

  // R8
  status_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy && $past(rd && busy)) |-> data_o[6] != $past(data_o[6]));

  // R9
  busy_decoder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> dec_idle);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !(wr && data_i == 8'hF0)) |=> err);

  // R10
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && err) |-> data_o[5]);
endmodule

bind nor_flash_cmd nor_flash_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .data_i   (data_i),
  .data_o   (data_o),
  .busy     (op_busy),
  .err      (op_err),
  .dec_idle (dec_idle)
);

// File: tb/nor_flash_cmd_tb.sv
`timescale 1ns/1ps
module nor_flash_cmd_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] prot = 4'b0000;

  always #2.5 clk = ~clk;

  nor_flash_cmd u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(din), .data_o(dout),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .protect_i(prot)
  );

  int n_vec = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [7:0] last_q;

  // behavioural reference
  int m_ms = 0, m_op = 0, m_cnt = 0;
  logic [6:0] m_pa = '0;
  logic [7:0] m_pd = 8'hFF;
  logic m_tog = 1'b0;
  int erq[$];
  logic [7:0] mm [128];

  function automatic logic [7:0] expect_out(int kind, logic [10:0] a);
    if (kind != 2) return 8'h00;
    if (m_op != 0) return {~((m_op == 2) ? 1'b1 : m_pd[7]), m_tog, (m_op == 3), 5'b0};
    return mm[a[6:0]];
  endfunction

  task automatic model_reset();
    m_ms = 0; m_op = 0; m_cnt = 0; m_tog = 1'b0; erq.delete();
  endtask

  task automatic model_edge(int kind, logic [10:0] a, logic [7:0] d);
    logic [7:0] old;
    int idx;
    if (kind == 2 && m_op != 0) m_tog = ~m_tog;
    case (m_op)
      1: begin
        if (m_cnt == 7) begin
          old = mm[m_pa];
          mm[m_pa] = old & m_pd;
          m_op = ((m_pd & ~old) != 8'h00) ? 3 : 0;
        end else m_cnt++;
      end
      2: begin
        idx = erq[0] * 32 + (m_cnt % 32);
        mm[idx] = (m_cnt < 32) ? 8'h00 : 8'hFF;
        if (m_cnt == 63) begin
          void'(erq.pop_front());
          m_cnt = 0;
          if (erq.size() == 0) m_op = 0;
        end else m_cnt++;
      end
      3: if (kind == 1 && d == 8'hF0) m_op = 0;
      default: if (kind == 1) begin
        case (m_ms)
          0: m_ms = (a == 11'h555 && d == 8'hAA) ? 1 : 0;
          1: m_ms = (a == 11'h2AA && d == 8'h55) ? 2 : 0;
          2: m_ms = (a == 11'h555 && d == 8'hA0) ? 3 : (a == 11'h555 && d == 8'h80) ? 4 : 0;
          3: begin m_pa = a[6:0]; m_pd = d; m_op = 1; m_cnt = 0; m_ms = 0; end
          4: m_ms = (a == 11'h555 && d == 8'hAA) ? 5 : 0;
          5: m_ms = (a == 11'h2AA && d == 8'h55) ? 6 : 0;
          6: begin
            if (a == 11'h555 && d == 8'h10) begin
              for (int s = 0; s < 4; s++) if (!prot[s]) erq.push_back(s);
            end else if (d == 8'h30) begin
              if (!prot[a[6:5]]) erq.push_back(int'(a[6:5]));
            end
            if (erq.size() > 0) begin m_op = 2; m_cnt = 0; end
            m_ms = 0;
          end
          default: m_ms = 0;
        endcase
      end
    endcase
  endtask

  task automatic cyc(int kind, logic [10:0] a, logic [7:0] d);
    logic [7:0] e;
    @(negedge clk);
    addr = a; din = d;
    ce_n = (kind == 0); we_n = (kind != 1); oe_n = (kind != 2);
    #1;
    e = expect_out(kind, a);
    last_q = dout;
    n_vec++;
    if (dout !== e) begin
      n_fail++;
      $display("FAIL %s: addr=%h data_o=%h expected=%h", cur_req, a, dout, e);
    end
    @(posedge clk);
    model_edge(kind, a, d);
  endtask

  task automatic lit(logic [7:0] val, string req);
    n_vec++;
    if (last_q !== val) begin
      n_fail++;
      $display("FAIL %s: data_o=%h expected=%h", req, last_q, val);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d); cyc(1, a, d); endtask
  task automatic rd(logic [10:0] a); cyc(2, a, 8'h00); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 11'h0, 8'h00); endtask
  task automatic unlock(); wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); endtask
  task automatic prog(logic [10:0] a, logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask
  task automatic erase_pre(); unlock(); wr(11'h555, 8'h80); unlock(); endtask
  task automatic chip_erase(); erase_pre(); wr(11'h555, 8'h10); endtask
  task automatic sect_erase(logic [1:0] s); erase_pre(); wr({4'b0, s, 5'b0}, 8'h30); endtask
  task automatic poll(logic [10:0] a);
    for (int g = 0; g < 2000 && (m_op == 1 || m_op == 2); g++) rd(a);
  endtask
  task automatic hw_reset();
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; rst_ni = 1'b0;
    model_reset();
    #1;
    last_q = dout;
    lit(8'h00, "R11");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    hw_reset();
    cur_req = "R1"; idle(3); lit(8'h00, "R1");

    // R4 R7 R8: full erase, polled with status reads
    cur_req = "R4"; prot = 4'b0000; chip_erase(); poll(11'h010);
    rd(11'h010); lit(8'hFF, "R4"); rd(11'h07F); lit(8'hFF, "R7");

    // R2: program, AND semantics, any order
    cur_req = "R2";
    prog(11'h012, 8'hA5); rd(11'h012); lit(8'h00, "R8"); poll(11'h012);
    rd(11'h012); lit(8'hA5, "R2");
    prog(11'h070, 8'h3C); poll(11'h070); prog(11'h005, 8'h81); poll(11'h005);
    rd(11'h070); lit(8'h3C, "R2"); rd(11'h005); lit(8'h81, "R2");
    prog(11'h012, 8'h21); poll(11'h012); rd(11'h012); lit(8'h21, "R2");

    // R10: raising a 0 fails and sticks
    cur_req = "R10";
    prog(11'h012, 8'h80); poll(11'h012);
    rd(11'h012); lit(8'h20 | 8'h00, "R10"); rd(11'h012);
    unlock(); wr(11'h555, 8'hA0); wr(11'h013, 8'h00);
    rd(11'h012); lit(8'h20 | (last_q & 8'h40), "R10");
    wr(11'h000, 8'hF0); rd(11'h012); lit(8'h00, "R10"); rd(11'h013); lit(8'hFF, "R10");

    // R9: writes during busy ignored
    cur_req = "R9";
    prog(11'h040, 8'h5A); prog(11'h041, 8'h00); poll(11'h040);
    rd(11'h041); lit(8'hFF, "R9"); rd(11'h040); lit(8'h5A, "R9");

    // R3: broken sequences
    cur_req = "R3";
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'h030, 8'h00);
    rd(11'h030); lit(8'hFF, "R3");
    wr(11'h555, 8'hAA); wr(11'h000, 8'hF0); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
    wr(11'h031, 8'h00); rd(11'h031); lit(8'hFF, "R3");
    erase_pre(); wr(11'h2AA, 8'h10); rd(11'h012); lit(8'h00, "R3");

    // R5 R6: sector erase and protection
    cur_req = "R6";
    prog(11'h025, 8'h00); poll(11'h025); prog(11'h045, 8'h00); poll(11'h045);
    prot = 4'b0100; sect_erase(2'd2); rd(11'h045); lit(8'h00, "R6");
    cur_req = "R5"; sect_erase(2'd1); poll(11'h025);
    rd(11'h025); lit(8'hFF, "R5"); rd(11'h045); lit(8'h00, "R5");
    cur_req = "R6"; chip_erase(); poll(11'h000);
    rd(11'h045); lit(8'h00, "R6"); rd(11'h040); lit(8'h5A, "R6");
    rd(11'h012); lit(8'hFF, "R6"); rd(11'h070); lit(8'hFF, "R6");
    prot = 4'b0000;

    // R11: abort program and erase
    cur_req = "R11";
    prog(11'h060, 8'h00); idle(3); hw_reset(); rd(11'h060); lit(8'hFF, "R11");
    sect_erase(2'd0); idle(40); hw_reset();
    rd(11'h018); lit(8'h00, "R7"); rd(11'h000); lit(8'hFF, "R7"); rd(11'h01F); lit(8'h00, "R11");
    rd(11'h025); lit(8'hFF, "R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule